// File: doc/BRIEF.md
# Debug claim tag register pair

This block keeps a small group of claim tag bits. Debug agents use these bits to mark which debug functions they have taken. The same tag state is seen through two 64-bit register views. The set view always reads back a fixed mask of the tag positions that exist. Each one written to it raises the matching tag. The clear view reads back the live tags. Each one written to it lowers the matching tag. Neither view supports a plain overwrite, so agents never disturb each other's claims.

Two access ports reach the same state: one serves system-instruction accesses and the other serves external register accesses. Each port has a select, a write enable, a view select (0 selects the set view, 1 selects the clear view), 64-bit write data, and 64-bit read data. Read data is combinational and shows the state before any write in the same cycle. A write becomes visible from the following cycle. The parameter `NUM_TAGS` sets the number of implemented tags, from 4 to 32. Implemented tags sit in bits `NUM_TAGS-1` down to 0.

Top module: `claim_tag_regs`

## Requirements
- R1: Bits 63 to 32 of read data are always zero on both views, and write data in bits 63 to 32 has no effect on any tag.
- R2: A read of the set view (view select 0) returns one in each of bits `NUM_TAGS-1`..0 and zero elsewhere, whatever the tag values; with the default of 8 tags this is 0xFF.
- R3: Writing the set view with bit m at one raises tag m; bits written as zero leave their tags unchanged.
- R4: A read of the clear view (view select 1) returns the current tags in bits `NUM_TAGS-1`..0.
- R5: Writing the clear view with bit m at one lowers tag m; bits written as zero leave their tags unchanged.
- R6: Writes to tag positions at or above `NUM_TAGS` are ignored, so a clear-view read always returns zero there.
- R7: While reset is asserted, and after reset is released, every tag is zero.
- R8: When one port sets and another port clears the same tag in the same cycle, the tag ends at one.
- R9: Both ports act on the same tag state. Writes from the two ports in the same cycle both take effect.
- R10: A port's read data is zero unless that port is selected with write enable low.
- R11: A write changes read data only from the next cycle on. A read on the other port in the same cycle returns the earlier value. With no write in a cycle, the tags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_sel | input | 1 | System-instruction port select |
| sys_wr | input | 1 | System-instruction port write enable |
| sys_view | input | 1 | System-instruction port view: 0 set, 1 clear |
| sys_wdata | input | 64 | System-instruction port write data |
| sys_rdata | output | 64 | System-instruction port read data |
| ext_sel | input | 1 | External port select |
| ext_wr | input | 1 | External port write enable |
| ext_view | input | 1 | External port view: 0 set, 1 clear |
| ext_wdata | input | 64 | External port write data |
| ext_rdata | output | 64 | External port read data |

## Verification
Two things can happen in the same cycle: a set from one port and a clear of the same tag from the other port. A write on one port can also coincide with a read on the other. The bench forces both cases directly: a set of 0x81 on one port against a clear of 0x81 on the other, and a write paired with a read. It then keeps producing such collisions with random traffic on both ports at once. Every result is judged against a bench model. The model applies clears first and sets second, masks the result to the implemented tags, and uses the state from before the cycle for reads made in that cycle.

// File: rtl/claim_tag_pkg.sv
package claim_tag_pkg;

  localparam int unsigned REG_W    = 64;
  localparam int unsigned MAX_TAGS = 32;

  typedef enum logic {
    VIEW_SET = 1'b0,
    VIEW_CLR = 1'b1
  } view_e;

  typedef logic [REG_W-1:0] reg_word_t;

endpackage

// File: rtl/claim_tag_rst_sync.sv
module claim_tag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/claim_tag_port.sv
module claim_tag_port
  import claim_tag_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr,
  input  logic                view,
  input  reg_word_t           wdata,
  input  logic [NUM_TAGS-1:0] tags,
  output logic [NUM_TAGS-1:0] set_req,
  output logic [NUM_TAGS-1:0] clr_req,
  output reg_word_t           rdata
);

  view_e view_q;
  logic  wr_hit;
  logic  rd_hit;
  logic  unused_wdata_hi;

  assign view_q          = view_e'(view);
  assign wr_hit          = sel && wr;
  assign rd_hit          = sel && !wr;
  assign unused_wdata_hi = ^wdata[REG_W-1:NUM_TAGS];

  // Write decode: only the implemented slice reaches the tag state.
  always_comb begin
    set_req = '0;
    clr_req = '0;
    if (wr_hit) begin
      if (view_q == VIEW_SET) begin
        set_req = wdata[NUM_TAGS-1:0];
      end else begin
        clr_req = wdata[NUM_TAGS-1:0];
      end
    end
  end

  // Read mux: set view returns the implemented mask, clear view the live tags.
  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      if (view_q == VIEW_SET) begin
        rdata[NUM_TAGS-1:0] = '1;
      end else begin
        rdata[NUM_TAGS-1:0] = tags;
      end
    end
  end

  // R1: upper half never carries data
  a_r1_upper_zero : assert property (@(posedge clk) disable iff (!rst_n)
    rdata[REG_W-1:MAX_TAGS] == '0);

  // R10: no read, no data
  a_r10_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rdata == '0));

  // R6: clear-view read is empty above the implemented tags
  a_r6_clr_view_bounds : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && view_q == VIEW_CLR) |-> (rdata[REG_W-1:NUM_TAGS] == '0));

  // R4: clear-view read follows the tag state
  a_r4_clr_view_live : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && view_q == VIEW_CLR) |-> (rdata[NUM_TAGS-1:0] == tags));

  // R2: set-view read is the full implemented mask
  a_r2_set_view_mask : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && view_q == VIEW_SET) |-> (rdata[NUM_TAGS-1:0] == {NUM_TAGS{1'b1}}));

endmodule

// File: rtl/claim_tag_state.sv
module claim_tag_state #(
  parameter int unsigned NUM_TAGS  = 8,
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_PORTS-1:0][NUM_TAGS-1:0] set_req,
  input  logic [NUM_PORTS-1:0][NUM_TAGS-1:0] clr_req,
  output logic [NUM_TAGS-1:0]                tags
);

  logic [NUM_TAGS-1:0] set_all;
  logic [NUM_TAGS-1:0] clr_all;
  logic [NUM_TAGS-1:0] tags_nxt;
  logic                tags_en;

  // Merge requests from all ports.
  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      set_all = set_all | set_req[p];
      clr_all = clr_all | clr_req[p];
    end
  end

  // Clear first, then set: a set on the same bit wins.
  always_comb begin
    tags_en  = (|set_all) || (|clr_all);
    tags_nxt = (tags & ~clr_all) | set_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tags <= '0;
    end else if (tags_en) begin
      tags <= tags_nxt;
    end
  end

  // R3: every requested set is present next cycle
  a_r3_set_lands : assert property (@(posedge clk) disable iff (!rst_n)
    (|set_all) |=> ((tags & $past(set_all)) == $past(set_all)));

  // R5: a clear with no competing set leaves the bit low
  a_r5_clear_lands : assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_all & ~set_all)) |=> ((tags & $past(clr_all & ~set_all)) == '0));

  // R8: conflicting set and clear resolve to one
  a_r8_set_beats_clear : assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_all & set_all)) |=> ((tags & $past(clr_all & set_all)) == $past(clr_all & set_all)));

  // R11: without requests the tags hold
  a_r11_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_all) && !(|clr_all)) |=> $stable(tags));

  // R7: reset leaves no tag raised
  a_r7_reset_clear : assert property (@(posedge clk)
    !rst_n |-> (tags == '0));

endmodule

// File: rtl/claim_tag_regs.sv
module claim_tag_regs
  import claim_tag_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sys_sel,
  input  logic        sys_wr,
  input  logic        sys_view,
  input  logic [63:0] sys_wdata,
  output logic [63:0] sys_rdata,
  input  logic        ext_sel,
  input  logic        ext_wr,
  input  logic        ext_view,
  input  logic [63:0] ext_wdata,
  output logic [63:0] ext_rdata
);

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned P_SYS     = 0;
  localparam int unsigned P_EXT     = 1;

  logic                               rst_n_int;
  logic [NUM_TAGS-1:0]                tags;
  logic [NUM_PORTS-1:0][NUM_TAGS-1:0] set_req;
  logic [NUM_PORTS-1:0][NUM_TAGS-1:0] clr_req;
  logic [NUM_PORTS-1:0]               p_sel;
  logic [NUM_PORTS-1:0]               p_wr;
  logic [NUM_PORTS-1:0]               p_view;
  reg_word_t                          p_wdata [NUM_PORTS];
  reg_word_t                          p_rdata [NUM_PORTS];

  claim_tag_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_int)
  );

  assign p_sel[P_SYS]   = sys_sel;
  assign p_wr[P_SYS]    = sys_wr;
  assign p_view[P_SYS]  = sys_view;
  assign p_wdata[P_SYS] = sys_wdata;
  assign p_sel[P_EXT]   = ext_sel;
  assign p_wr[P_EXT]    = ext_wr;
  assign p_view[P_EXT]  = ext_view;
  assign p_wdata[P_EXT] = ext_wdata;
  assign sys_rdata      = p_rdata[P_SYS];
  assign ext_rdata      = p_rdata[P_EXT];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    claim_tag_port #(
      .NUM_TAGS(NUM_TAGS)
    ) u_port (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .sel    (p_sel[g]),
      .wr     (p_wr[g]),
      .view   (p_view[g]),
      .wdata  (p_wdata[g]),
      .tags   (tags),
      .set_req(set_req[g]),
      .clr_req(clr_req[g]),
      .rdata  (p_rdata[g])
    );
  end

  claim_tag_state #(
    .NUM_TAGS (NUM_TAGS),
    .NUM_PORTS(NUM_PORTS)
  ) u_state (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .set_req(set_req),
    .clr_req(clr_req),
    .tags   (tags)
  );

  // R9: both ports see identical clear-view data when reading together
  a_r9_shared_state : assert property (@(posedge clk) disable iff (!rst_n_int)
    (sys_sel && !sys_wr && sys_view && ext_sel && !ext_wr && ext_view)
      |-> (sys_rdata == ext_rdata));

endmodule

// File: tb/claim_tag_regs_bench.sv
module claim_tag_regs_bench;

  localparam int unsigned NT = 8;
  localparam logic [63:0] IMPL = (64'd1 << NT) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sys_sel, sys_wr, sys_view;
  logic [63:0] sys_wdata, sys_rdata;
  logic        ext_sel, ext_wr, ext_view;
  logic [63:0] ext_wdata, ext_rdata;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [63:0] m_tags;

  always #5 clk = ~clk;

  claim_tag_regs #(.NUM_TAGS(NT)) u_claim_tag_regs (
    .clk(clk), .rst_n(rst_n),
    .sys_sel(sys_sel), .sys_wr(sys_wr), .sys_view(sys_view),
    .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
    .ext_sel(ext_sel), .ext_wr(ext_wr), .ext_view(ext_view),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  function automatic logic [63:0] next_tags(logic [63:0] t, logic [63:0] s, logic [63:0] c);
    return ((t & ~c) | s) & IMPL;
  endfunction

  function automatic logic [63:0] read_exp(logic sel, logic wr, logic view, logic [63:0] t);
    if (!(sel && !wr)) return 64'd0;
    return view ? (t & IMPL) : IMPL;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string rd_tag(logic sel, logic wr, logic view);
    if (!(sel && !wr)) return "R10 idle read data";
    return view ? "R4/R6 clear view read" : "R2 set view read";
  endfunction

  task automatic set_inputs(logic ss, logic sw, logic sv, logic [63:0] sd,
                            logic es, logic ew, logic ev, logic [63:0] ed);
    sys_sel = ss; sys_wr = sw; sys_view = sv; sys_wdata = sd;
    ext_sel = es; ext_wr = ew; ext_view = ev; ext_wdata = ed;
  endtask

  // Called just after a falling edge. Checks reads against pre-write state,
  // updates the model, then waits for the next falling edge.
  task automatic step(logic ss, logic sw, logic sv, logic [63:0] sd,
                      logic es, logic ew, logic ev, logic [63:0] ed);
    logic [63:0] s_m, c_m;
    set_inputs(ss, sw, sv, sd, es, ew, ev, ed);
    #1;
    chk({"sys ", rd_tag(ss, sw, sv), " (R1 R11)"}, sys_rdata, read_exp(ss, sw, sv, m_tags));
    chk({"ext ", rd_tag(es, ew, ev), " (R1 R11)"}, ext_rdata, read_exp(es, ew, ev, m_tags));
    s_m = 64'd0; c_m = 64'd0;
    if (ss && sw) begin if (sv) c_m |= sd; else s_m |= sd; end
    if (es && ew) begin if (ev) c_m |= ed; else s_m |= ed; end
    m_tags = next_tags(m_tags, s_m, c_m);
    @(negedge clk);
  endtask

  task automatic idle_read_clr(string req, logic [63:0] exp);
    step(1'b1, 1'b0, 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, 64'd0);
    chk(req, m_tags, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    m_tags = 64'd0;
    set_inputs(1'b0, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 64'd0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R7: during reset, clear view shows nothing
    sys_sel = 1'b1; sys_view = 1'b1; #1;
    chk("R7 clear view in reset", sys_rdata, 64'd0);
    sys_sel = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 after release, R2 set view mask
    step(1'b1, 1'b0, 1'b1, 64'd0, 1'b1, 1'b0, 1'b0, 64'd0);
    chk("R7 tags after reset", m_tags, 64'd0);
    step(1'b0, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 64'd0);
    #1 chk("R2 literal set view", 64'hFF, IMPL);

    // R3: set 0x05 through sys
    step(1'b1, 1'b1, 1'b0, 64'h5, 1'b0, 1'b0, 1'b0, 64'd0);
    idle_read_clr("R3 set 0x05", 64'h05);
    // R3 zeros keep: set 0x40 keeps 0x05
    step(1'b1, 1'b1, 1'b0, 64'h40, 1'b0, 1'b0, 1'b0, 64'd0);
    idle_read_clr("R3 zeros keep", 64'h45);
    // R2 with nonzero tags
    step(1'b0, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 64'd0);

    // R1/R6: set all ones from ext, only implemented bits rise
    step(1'b0, 1'b0, 1'b0, 64'd0, 1'b1, 1'b1, 1'b0, {64{1'b1}});
    idle_read_clr("R1 R6 set all ones", 64'hFF);
    // R5: clear 0x0F plus upper bits
    step(1'b0, 1'b0, 1'b0, 64'd0, 1'b1, 1'b1, 1'b1, 64'hFFFF_0000_0000_000F);
    idle_read_clr("R5 clear low nibble", 64'hF0);

    // R8: sys sets 0x81 while ext clears 0x81 and 0x10
    step(1'b1, 1'b1, 1'b0, 64'h81, 1'b1, 1'b1, 1'b1, 64'h91);
    idle_read_clr("R8 set beats clear", 64'hE1);

    // R9: both ports set in one cycle
    step(1'b1, 1'b1, 1'b0, 64'h02, 1'b1, 1'b1, 1'b0, 64'h04);
    idle_read_clr("R9 dual set", 64'hE7);

    // R11: ext reads clear view while sys clears; read sees old value
    step(1'b1, 1'b1, 1'b1, 64'hFF, 1'b1, 1'b0, 1'b1, 64'd0);
    idle_read_clr("R11 write then read", 64'h00);

    // Random traffic on both ports
    for (int i = 0; i < 600; i++) begin
      logic [63:0] sd, ed;
      sd = {$urandom, $urandom};
      ed = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) sd &= 64'h0000_0000_0000_00FF;
      if ($urandom_range(0, 2) == 0) ed = sd;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, sd,
           $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, ed);
    end
    step(1'b1, 1'b0, 1'b1, 64'd0, 1'b1, 1'b0, 1'b0, 64'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule